// File: doc/BRIEF.md
# Block DMA Controller Between Main Memory and DSP Memories

This block is a register-programmed copy engine that sits on the DSP's 16-bit register bus. Software first sets up a 32-bit main-memory byte address, a DSP word address and a 2-bit transfer mode. It then writes a byte count into the length register, and that write starts the transfer. The engine copies 16-bit words one at a time between a simple main-memory port and either the DSP data memory or the DSP instruction memory. It swaps the two bytes of every word on the way.

Before starting, each launch is checked against three rules. The control word must be valid, the length must fit the limit, and a data-memory transfer must use an address inside the allowed main-memory window. A launch that fails the check raises an error flag and moves nothing. Completion shows in three ways: a one-cycle done pulse, the busy flag falling, and the busy bit in the control register clearing. The combination that copies instruction memory out to main memory is accepted but moves nothing.

Top module: `dsp_blkdma`

## Requirements
- R1: After a synchronous active-low reset, every register reads back as zero. Busy, err and done are low, and no memory strobe is active.
- R2: Register offsets are:
  - control at 0xC8, with mode in bits 1:0, a read-only busy bit in bit 2 and a read-only error bit in bit 3;
  - length in bytes at 0xCB;
  - main-memory address high half at 0xCC and low half at 0xCD, forming {high, low};
  - DSP word address at 0xCE.
  Writes to the address registers and the length register read back unchanged.
- R3: A length write while idle launches a transfer. The busy output and control bit 2 stay high from the cycle after the write until the last word is written. Done pulses for one cycle as busy falls, and no memory strobe is active outside busy.
- R4: Mode 1 copies main memory into data memory. Data-memory word dsp+k receives the byte-swapped word read from main-memory byte address base+2k.
- R5: Mode 0 copies data memory to main memory. Main-memory byte address base+2k receives the byte-swapped data-memory word dsp+k.
- R6: Mode 3 copies main memory into instruction memory. Instruction-memory word dsp+k receives the byte-swapped word from main-memory byte address base+2k, and data memory is not written.
- R7: Mode 2 (instruction memory to main memory) moves no data and never raises busy. It still gives one done pulse.
- R8: The number of words moved is the byte length divided by two, rounded up. A zero length writes nothing, never raises busy, and gives one done pulse.
- R9: A launch is refused if the control value last written is above 3, or if the length is above 0x4000. A refused launch sets err, moves nothing and gives no done pulse. A length of exactly 0x4000 is accepted.
- R10: For modes 0 and 1, a launch is refused with err if the main-memory address with bit 31 cleared is above 0x01FFFFFF. Modes 2 and 3 do not apply this check.
- R11: A length write while busy is ignored. The stored length and the transfer in progress are both unchanged.
- R12: An accepted launch clears err.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the addressed register (combinational) |
| mm_addr | output | 32 | Main-memory byte address |
| mm_re | output | 1 | Main-memory read strobe, data returned next cycle |
| mm_we | output | 1 | Main-memory write strobe |
| mm_wdata | output | 16 | Main-memory write data |
| mm_rdata | input | 16 | Main-memory read data |
| dm_addr | output | 8 | Data-memory word address |
| dm_re | output | 1 | Data-memory read strobe, data returned next cycle |
| dm_we | output | 1 | Data-memory write strobe |
| dm_wdata | output | 16 | Data-memory write data |
| dm_rdata | input | 16 | Data-memory read data |
| im_addr | output | 8 | Instruction-memory word address |
| im_we | output | 1 | Instruction-memory write strobe |
| im_wdata | output | 16 | Instruction-memory write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when a launch completes |
| err | output | 1 | Last launch was refused |

## Verification
A wrong word counter or pointer shows up in memory contents. It would be one word too many or too few, or a shifted destination, visible as soon as busy drops; that takes two cycles per word after launch. A mode register latched wrongly strobes the wrong memory on the first write beat. A faulty launch check shows in the err output and in the control readback on the cycle after the length write. A stuck state machine leaves busy high and never pulses done.

// File: rtl/dsp_blkdma_pkg.sv
// Shared constants, state type and helpers for the block DMA controller.
// Assumes an 8-bit register offset space on the DSP register bus.
package dsp_blkdma_pkg;

    localparam logic [7:0] OFS_CTRL  = 8'hC8;
    localparam logic [7:0] OFS_LEN   = 8'hCB;
    localparam logic [7:0] OFS_MM_HI = 8'hCC;
    localparam logic [7:0] OFS_MM_LO = 8'hCD;
    localparam logic [7:0] OFS_DSP   = 8'hCE;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } dma_state_t;

    // Exchange the two bytes of a 16-bit word.
    function automatic logic [15:0] swap16(input logic [15:0] w);
        return {w[7:0], w[15:8]};
    endfunction

endpackage

// File: rtl/dsp_blkdma_regs.sv
// Register file of the DMA controller: address, DSP pointer, mode and length.
// Produces the launch strobe when the length is written while idle.
// Assumes single-cycle register writes; reads are combinational.
module dsp_blkdma_regs
    import dsp_blkdma_pkg::*;
#(
    parameter int RW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [7:0]      reg_addr,
    input  logic [RW-1:0]   reg_wdata,
    output logic [RW-1:0]   reg_rdata,
    input  logic            busy,
    input  logic            err,
    output logic [2*RW-1:0] mm_base,
    output logic [RW-1:0]   dsp_base,
    output logic [1:0]      mode,
    output logic            ctrl_bad,
    output logic [RW-1:0]   len_q,
    output logic            launch
);

    // Register writes; length only accepted while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mm_base  <= '0;
            dsp_base <= '0;
            mode     <= '0;
            ctrl_bad <= 1'b0;
            len_q    <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                OFS_CTRL: begin
                    mode     <= reg_wdata[1:0];
                    ctrl_bad <= |reg_wdata[RW-1:2];
                end
                OFS_LEN:   if (!busy) len_q <= reg_wdata;
                OFS_MM_HI: mm_base[2*RW-1:RW] <= reg_wdata;
                OFS_MM_LO: mm_base[RW-1:0] <= reg_wdata;
                OFS_DSP:   dsp_base <= reg_wdata;
                default: ;
            endcase
        end
    end

    // Launch strobe: length write while no transfer runs.
    assign launch = reg_we && (reg_addr == OFS_LEN) && !busy;

    // Readback multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL: begin
                reg_rdata[1:0] = mode;
                reg_rdata[2]   = busy;
                reg_rdata[3]   = err;
            end
            OFS_LEN:   reg_rdata = len_q;
            OFS_MM_HI: reg_rdata = mm_base[2*RW-1:RW];
            OFS_MM_LO: reg_rdata = mm_base[RW-1:0];
            OFS_DSP:   reg_rdata = dsp_base;
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dsp_blkdma_launch_chk.sv
// Combinational validation of a launch request and word-count derivation.
// Assumes the length being written is presented directly from the bus.
module dsp_blkdma_launch_chk #(
    parameter int              RW       = 16,
    parameter logic [RW-1:0]   MAX_LEN  = 16'h4000,
    parameter logic [2*RW-1:0] DM_LIMIT = 32'h01FF_FFFF
) (
    input  logic [1:0]      mode,
    input  logic            ctrl_bad,
    input  logic [2*RW-2:0] mm_low,
    input  logic [RW-1:0]   len,
    output logic            fault,
    output logic            noop,
    output logic [RW-1:0]   words
);

    logic [RW:0]     len_p1;
    logic [2*RW-1:0] mm_masked;
    logic            len_bad;
    logic            range_bad;

    // Word count rounds odd byte lengths up.
    always_comb begin
        len_p1    = {1'b0, len} + 1'b1;
        words     = RW'(len_p1 >> 1);
        mm_masked = {1'b0, mm_low};
        len_bad   = len > MAX_LEN;
        range_bad = !mode[1] && (mm_masked > DM_LIMIT);
        fault     = ctrl_bad || len_bad || range_bad;
        noop      = (mode == 2'd2) || (words == '0);
    end

endmodule

// File: rtl/dsp_blkdma_engine.sv
// Transfer engine: one read beat then one write beat per 16-bit word,
// with byte swapping. Assumes both memories return read data one cycle
// after the read strobe.
module dsp_blkdma_engine
    import dsp_blkdma_pkg::*;
#(
    parameter int RW    = 16,
    parameter int DM_AW = 8,
    parameter int IM_AW = 8,
    parameter int PW    = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            launch,
    input  logic            fault,
    input  logic            noop,
    input  logic [RW-1:0]   words,
    input  logic [1:0]      mode,
    input  logic [2*RW-1:0] mm_base,
    input  logic [PW-1:0]   dsp_base,
    output logic [2*RW-1:0] mm_addr,
    output logic            mm_re,
    output logic            mm_we,
    output logic [RW-1:0]   mm_wdata,
    input  logic [RW-1:0]   mm_rdata,
    output logic [DM_AW-1:0] dm_addr,
    output logic            dm_re,
    output logic            dm_we,
    output logic [RW-1:0]   dm_wdata,
    input  logic [RW-1:0]   dm_rdata,
    output logic [IM_AW-1:0] im_addr,
    output logic            im_we,
    output logic [RW-1:0]   im_wdata,
    output logic            busy,
    output logic            done,
    output logic            err
);

    dma_state_t      state;
    logic [RW-1:0]   rem;
    logic [2*RW-1:0] mm_ptr;
    logic [PW-1:0]   ptr;
    logic [1:0]      mode_q;

    // Sequencer: accept or refuse launch, then alternate read/write beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            rem    <= '0;
            mm_ptr <= '0;
            ptr    <= '0;
            mode_q <= '0;
            done   <= 1'b0;
            err    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (launch) begin
                        if (fault) begin
                            err <= 1'b1;
                        end else begin
                            err <= 1'b0;
                            if (noop) begin
                                done <= 1'b1;
                            end else begin
                                state  <= ST_READ;
                                rem    <= words;
                                mm_ptr <= mm_base;
                                ptr    <= dsp_base;
                                mode_q <= mode;
                            end
                        end
                    end
                end
                ST_READ: state <= ST_WRITE;
                ST_WRITE: begin
                    if (rem == RW'(1)) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        rem    <= rem - 1'b1;
                        mm_ptr <= mm_ptr + 2'd2;
                        ptr    <= ptr + 1'b1;
                        state  <= ST_READ;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Strobe and data steering from the latched mode.
    always_comb begin
        busy     = state != ST_IDLE;
        mm_re    = (state == ST_READ) && mode_q[0];
        dm_re    = (state == ST_READ) && !mode_q[0];
        mm_we    = (state == ST_WRITE) && !mode_q[0];
        dm_we    = (state == ST_WRITE) && mode_q[0] && !mode_q[1];
        im_we    = (state == ST_WRITE) && mode_q[0] && mode_q[1];
        mm_addr  = mm_ptr;
        dm_addr  = ptr[DM_AW-1:0];
        im_addr  = ptr[IM_AW-1:0];
        mm_wdata = swap16(dm_rdata);
        dm_wdata = swap16(mm_rdata);
        im_wdata = swap16(mm_rdata);
    end

endmodule

// File: rtl/dsp_blkdma.sv
// Top of the block DMA controller between main memory and the DSP's
// data and instruction memories. Assumes 16-bit registers and words.
module dsp_blkdma #(
    parameter int          RW       = 16,
    parameter int          DM_AW    = 8,
    parameter int          IM_AW    = 8,
    parameter logic [15:0] MAX_LEN  = 16'h4000,
    parameter logic [31:0] DM_LIMIT = 32'h01FF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [7:0]        reg_addr,
    input  logic [RW-1:0]     reg_wdata,
    output logic [RW-1:0]     reg_rdata,
    output logic [2*RW-1:0]   mm_addr,
    output logic              mm_re,
    output logic              mm_we,
    output logic [RW-1:0]     mm_wdata,
    input  logic [RW-1:0]     mm_rdata,
    output logic [DM_AW-1:0]  dm_addr,
    output logic              dm_re,
    output logic              dm_we,
    output logic [RW-1:0]     dm_wdata,
    input  logic [RW-1:0]     dm_rdata,
    output logic [IM_AW-1:0]  im_addr,
    output logic              im_we,
    output logic [RW-1:0]     im_wdata,
    output logic              busy,
    output logic              done,
    output logic              err
);

    localparam int MAW = 2 * RW;
    localparam int PW  = (DM_AW > IM_AW) ? DM_AW : IM_AW;

    logic [MAW-1:0] mm_base;
    logic [RW-1:0]  dsp_base;
    logic [1:0]     mode;
    logic           ctrl_bad;
    logic [RW-1:0]  len_q;
    logic           launch;
    logic           fault;
    logic           noop;
    logic [RW-1:0]  words;

    dsp_blkdma_regs #(.RW(RW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .busy(busy), .err(err),
        .mm_base(mm_base), .dsp_base(dsp_base), .mode(mode),
        .ctrl_bad(ctrl_bad), .len_q(len_q), .launch(launch)
    );

    dsp_blkdma_launch_chk #(
        .RW(RW), .MAX_LEN(RW'(MAX_LEN)), .DM_LIMIT(MAW'(DM_LIMIT))
    ) u_chk_launch (
        .mode(mode), .ctrl_bad(ctrl_bad), .mm_low(mm_base[MAW-2:0]),
        .len(reg_wdata), .fault(fault), .noop(noop), .words(words)
    );

    dsp_blkdma_engine #(
        .RW(RW), .DM_AW(DM_AW), .IM_AW(IM_AW), .PW(PW)
    ) u_engine (
        .clk(clk), .rst_n(rst_n),
        .launch(launch), .fault(fault), .noop(noop), .words(words),
        .mode(mode), .mm_base(mm_base), .dsp_base(dsp_base[PW-1:0]),
        .mm_addr(mm_addr), .mm_re(mm_re), .mm_we(mm_we),
        .mm_wdata(mm_wdata), .mm_rdata(mm_rdata),
        .dm_addr(dm_addr), .dm_re(dm_re), .dm_we(dm_we),
        .dm_wdata(dm_wdata), .dm_rdata(dm_rdata),
        .im_addr(im_addr), .im_we(im_we), .im_wdata(im_wdata),
        .busy(busy), .done(done), .err(err)
    );

endmodule

// File: rtl/dsp_blkdma_chk.sv
// Protocol checker for the block DMA controller, bound to the top.
// Assumes synchronous active-low reset.
module dsp_blkdma_chk #(
    parameter int RW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic          mm_re,
    input logic          mm_we,
    input logic          dm_re,
    input logic          dm_we,
    input logic          im_we,
    input logic [RW-1:0] len_q
);

    p_strobe_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_re || mm_we || dm_re || dm_we || im_we) |-> busy);

    p_done_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_fall_gives_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_single_dest_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mm_we, dm_we, im_we}));

    p_write_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_we || dm_we || im_we) |-> $past(mm_re || dm_re));

    p_refusal_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !busy);

    p_len_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(len_q));

endmodule

bind dsp_blkdma dsp_blkdma_chk #(.RW(RW)) u_prot_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
    .mm_re(mm_re), .mm_we(mm_we), .dm_re(dm_re), .dm_we(dm_we),
    .im_we(im_we), .len_q(len_q)
);

// File: tb/dsp_blkdma_bench.sv
module dsp_blkdma_bench;

    localparam int CLK_PERIOD = 10;

    localparam logic [7:0] A_CTRL = 8'hC8;
    localparam logic [7:0] A_LEN  = 8'hCB;
    localparam logic [7:0] A_HI   = 8'hCC;
    localparam logic [7:0] A_LO   = 8'hCD;
    localparam logic [7:0] A_DSP  = 8'hCE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [15:0] reg_wdata = 16'h0000;
    logic [15:0] reg_rdata;
    logic [31:0] mm_addr;
    logic        mm_re, mm_we;
    logic [15:0] mm_wdata;
    logic [15:0] mm_rdata;
    logic [7:0]  dm_addr;
    logic        dm_re, dm_we;
    logic [15:0] dm_wdata;
    logic [15:0] dm_rdata;
    logic [7:0]  im_addr;
    logic        im_we;
    logic [15:0] im_wdata;
    logic        busy, done, err;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsp_blkdma u_dsp_blkdma (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mm_addr(mm_addr), .mm_re(mm_re), .mm_we(mm_we),
        .mm_wdata(mm_wdata), .mm_rdata(mm_rdata),
        .dm_addr(dm_addr), .dm_re(dm_re), .dm_we(dm_we),
        .dm_wdata(dm_wdata), .dm_rdata(dm_rdata),
        .im_addr(im_addr), .im_we(im_we), .im_wdata(im_wdata),
        .busy(busy), .done(done), .err(err)
    );

    function automatic logic [15:0] mm_init(int i);
        logic [8:0] a;
        a = i[8:0];
        return {a[7:0] + 8'h31, a[8:1] ^ 8'hC3};
    endfunction

    function automatic logic [15:0] dm_init(int i);
        logic [7:0] a;
        a = i[7:0];
        return {a ^ 8'hA5, a + 8'h10};
    endfunction

    function automatic logic [15:0] sw(logic [15:0] w);
        return {w[7:0], w[15:8]};
    endfunction

    // Memory models: one-cycle read latency, re-initialised on reset.
    logic [15:0] mm_mem [0:511];
    logic [15:0] dm_mem [0:255];
    logic [15:0] im_mem [0:255];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 512; i++) mm_mem[i] <= mm_init(i);
            for (int i = 0; i < 256; i++) dm_mem[i] <= dm_init(i);
            for (int i = 0; i < 256; i++) im_mem[i] <= 16'hEEEE;
            mm_rdata <= 16'h0;
            dm_rdata <= 16'h0;
        end else begin
            if (mm_re) mm_rdata <= mm_mem[mm_addr[9:1]];
            if (mm_we) mm_mem[mm_addr[9:1]] <= mm_wdata;
            if (dm_re) dm_rdata <= dm_mem[dm_addr];
            if (dm_we) dm_mem[dm_addr] <= dm_wdata;
            if (im_we) im_mem[im_addr] <= im_wdata;
        end
    end

    // Event monitors.
    logic mon_clr = 1'b0;
    int cnt_done, cnt_mmwe, cnt_dmwe, cnt_imwe;

    always @(posedge clk) begin
        if (mon_clr) begin
            cnt_done <= 0; cnt_mmwe <= 0; cnt_dmwe <= 0; cnt_imwe <= 0;
        end else begin
            cnt_done <= cnt_done + int'(done);
            cnt_mmwe <= cnt_mmwe + int'(mm_we);
            cnt_dmwe <= cnt_dmwe + int'(dm_we);
            cnt_imwe <= cnt_imwe + int'(im_we);
        end
    end

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr_reg(logic [7:0] a, logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(logic [7:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic setup(logic [15:0] ctrl, logic [31:0] base, logic [15:0] dsp);
        wr_reg(A_CTRL, ctrl);
        wr_reg(A_HI, base[31:16]);
        wr_reg(A_LO, base[15:0]);
        wr_reg(A_DSP, dsp);
    endtask

    task automatic clr_mon();
        @(negedge clk);
        mon_clr = 1'b1;
        @(negedge clk);
        mon_clr = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 40000) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        do_reset();
        rd_reg(A_CTRL, d); check("R1", "ctrl", 32'(d), 32'h0);
        rd_reg(A_LEN, d);  check("R1", "len", 32'(d), 32'h0);
        rd_reg(A_HI, d);   check("R1", "hi", 32'(d), 32'h0);
        rd_reg(A_LO, d);   check("R1", "lo", 32'(d), 32'h0);
        rd_reg(A_DSP, d);  check("R1", "dsp", 32'(d), 32'h0);
        check("R1", "busy/err/done", {29'b0, busy, err, done}, 32'h0);
        check("R1", "strobes", {27'b0, mm_re, mm_we, dm_re, dm_we, im_we}, 32'h0);
    endtask

    task automatic t_in_dmem();
        logic [15:0] d;
        do_reset();
        setup(16'h1, 32'h0000_0040, 16'h0010);
        clr_mon();
        wr_reg(A_LEN, 16'd8);
        check("R3", "busy after launch", 32'(busy), 32'h1);
        rd_reg(A_CTRL, d); check("R3", "ctrl busy bit", 32'(d), 32'h5);
        wait_idle();
        rd_reg(A_CTRL, d); check("R3", "ctrl idle", 32'(d), 32'h1);
        check("R3", "done pulses", 32'(cnt_done), 32'd1);
        for (int k = 0; k < 4; k++)
            check("R4", "dmem word", 32'(dm_mem[16 + k]), 32'(sw(mm_init(32 + k))));
        check("R4", "dmem beyond", 32'(dm_mem[20]), 32'(dm_init(20)));
        rd_reg(A_HI, d);  check("R2", "hi readback", 32'(d), 32'h0000);
        rd_reg(A_LO, d);  check("R2", "lo readback", 32'(d), 32'h0040);
        rd_reg(A_DSP, d); check("R2", "dsp readback", 32'(d), 32'h0010);
        rd_reg(A_LEN, d); check("R2", "len readback", 32'(d), 32'h0008);
    endtask

    task automatic t_out_dmem();
        do_reset();
        setup(16'h0, 32'h0000_0100, 16'h0030);
        clr_mon();
        wr_reg(A_LEN, 16'd6);
        wait_idle();
        for (int k = 0; k < 3; k++)
            check("R5", "main word", 32'(mm_mem[128 + k]), 32'(sw(dm_init(48 + k))));
        check("R5", "main beyond", 32'(mm_mem[131]), 32'(mm_init(131)));
        check("R5", "done", 32'(cnt_done), 32'd1);
    endtask

    task automatic t_in_imem();
        do_reset();
        setup(16'h3, 32'h0000_0060, 16'h0005);
        clr_mon();
        wr_reg(A_LEN, 16'd4);
        wait_idle();
        for (int k = 0; k < 2; k++)
            check("R6", "imem word", 32'(im_mem[5 + k]), 32'(sw(mm_init(48 + k))));
        check("R6", "no dmem writes", 32'(cnt_dmwe), 32'd0);
        check("R6", "dmem untouched", 32'(dm_mem[5]), 32'(dm_init(5)));
    endtask

    task automatic t_imem_out();
        do_reset();
        setup(16'h2, 32'h0000_0040, 16'h0000);
        clr_mon();
        wr_reg(A_LEN, 16'd8);
        check("R7", "no busy", 32'(busy), 32'h0);
        wait_idle();
        check("R7", "done", 32'(cnt_done), 32'd1);
        check("R7", "writes", 32'(cnt_mmwe + cnt_dmwe + cnt_imwe), 32'd0);
        check("R7", "main untouched", 32'(mm_mem[32]), 32'(mm_init(32)));
        check("R7", "err", 32'(err), 32'h0);
    endtask

    task automatic t_odd_zero();
        do_reset();
        setup(16'h1, 32'h0000_0040, 16'h0020);
        clr_mon();
        wr_reg(A_LEN, 16'd5);
        wait_idle();
        check("R8", "odd count", 32'(cnt_dmwe), 32'd3);
        check("R8", "odd last", 32'(dm_mem[34]), 32'(sw(mm_init(34))));
        check("R8", "odd beyond", 32'(dm_mem[35]), 32'(dm_init(35)));
        setup(16'h1, 32'h0000_0080, 16'h0060);
        clr_mon();
        wr_reg(A_LEN, 16'd0);
        check("R8", "zero no busy", 32'(busy), 32'h0);
        wait_idle();
        check("R8", "zero done", 32'(cnt_done), 32'd1);
        check("R8", "zero writes", 32'(cnt_dmwe), 32'd0);
        check("R8", "zero dmem", 32'(dm_mem[96]), 32'(dm_init(96)));
    endtask

    task automatic t_errors();
        logic [15:0] d;
        do_reset();
        setup(16'h4, 32'h0000_0040, 16'h0000);
        clr_mon();
        wr_reg(A_LEN, 16'd2);
        check("R9", "bad ctrl err", 32'(err), 32'h1);
        check("R9", "bad ctrl busy", 32'(busy), 32'h0);
        wait_idle();
        check("R9", "bad ctrl done", 32'(cnt_done), 32'd0);
        check("R9", "bad ctrl writes", 32'(cnt_mmwe), 32'd0);
        rd_reg(A_CTRL, d); check("R9", "ctrl err bit", 32'(d), 32'h8);
        setup(16'h1, 32'h0000_0040, 16'h0000);
        clr_mon();
        wr_reg(A_LEN, 16'h4001);
        check("R9", "long err", 32'(err), 32'h1);
        wait_idle();
        check("R9", "long writes", 32'(cnt_dmwe), 32'd0);
        setup(16'h3, 32'h0000_0000, 16'h0000);
        clr_mon();
        wr_reg(A_LEN, 16'h4000);
        check("R12", "err cleared", 32'(err), 32'h0);
        check("R9", "max accepted", 32'(busy), 32'h1);
        wait_idle();
        check("R9", "max words", 32'(cnt_imwe), 32'd8192);
        check("R9", "max done", 32'(cnt_done), 32'd1);
    endtask

    task automatic t_range();
        do_reset();
        setup(16'h1, 32'h0200_0000, 16'h0000);
        clr_mon();
        wr_reg(A_LEN, 16'd2);
        check("R10", "out of window err", 32'(err), 32'h1);
        wait_idle();
        check("R10", "out of window writes", 32'(cnt_dmwe), 32'd0);
        setup(16'h1, 32'h8000_0040, 16'h0040);
        wr_reg(A_LEN, 16'd2);
        check("R10", "bit31 ignored", 32'(err), 32'h0);
        wait_idle();
        check("R10", "bit31 data", 32'(dm_mem[64]), 32'(sw(mm_init(32))));
        setup(16'h1, 32'h01FF_FFFE, 16'h0050);
        wr_reg(A_LEN, 16'd2);
        check("R10", "window edge", 32'(err), 32'h0);
        wait_idle();
        check("R10", "edge data", 32'(dm_mem[80]), 32'(sw(mm_init(511))));
        setup(16'h3, 32'h0200_0000, 16'h0060);
        wr_reg(A_LEN, 16'd2);
        check("R10", "imem unchecked", 32'(err), 32'h0);
        wait_idle();
        check("R10", "imem data", 32'(im_mem[96]), 32'(sw(mm_init(0))));
    endtask

    task automatic t_busy_len();
        logic [15:0] d;
        do_reset();
        setup(16'h1, 32'h0000_0040, 16'h0070);
        clr_mon();
        wr_reg(A_LEN, 16'd8);
        wr_reg(A_LEN, 16'd2);
        rd_reg(A_LEN, d); check("R11", "len held", 32'(d), 32'h8);
        wait_idle();
        check("R11", "word count", 32'(cnt_dmwe), 32'd4);
        check("R11", "done", 32'(cnt_done), 32'd1);
        check("R11", "last word", 32'(dm_mem[115]), 32'(sw(mm_init(35))));
    endtask

    initial begin
        t_reset();
        t_in_dmem();
        t_out_dmem();
        t_in_imem();
        t_imem_out();
        t_odd_zero();
        t_errors();
        t_range();
        t_busy_len();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule